// File: doc/BRIEF.md
# Glitch-Free System Clock Selector and Divider

This block produces the system clock of a small microcontroller from three incoming clocks: a high-frequency crystal or external clock, an on-chip ring oscillator and a low-frequency (nominally 32 kHz) clock. Software programs one 8-bit control byte through a single-cycle write port. The byte chooses the source, a divide ratio, and a low-power option. The low-power option turns two of the ratio codes into "divide by 256" and "run from the low-frequency clock".

Every change of source or ratio goes through a handshake multiplexer. The old clock's enable is withdrawn in its own domain before the new clock's enable is raised in its own domain, so the output never carries a runt pulse. A status bit in the same byte reports which source is actually driving the output, and it lags the request until the handshake is complete. The crystal path has a startup counter. Until that counter has finished, a request to go back to the crystal is held off and the output stays on the ring oscillator.

The control sequencer has four states:
- `SRC_XTAL`: the crystal drives the output.
- `SRC_TO_RING`: entered from `SRC_XTAL` when ring is requested. It is left when the ring enable is seen.
- `SRC_RING`: the ring oscillator drives the output.
- `SRC_TO_XTAL`: entered from `SRC_RING` when the crystal is requested and startup is done. It is left when the crystal enable is seen.

The startup counter has two states. `XW_COUNT` moves to `XW_DONE` after the programmed number of crystal cycles, and `XW_DONE` holds until reset.

Top module: `clkgen_top`

## Requirements
- R1: With bit 2 clear, bits [1:0] select the output period as the source period times 1 (00), 2 (01), 4 (10) or 8 (11).
- R2: With bit 2 set and bits [1:0] = 00, the output period is 256 source periods.
- R3: With bit 2 set, bits [1:0] = 11 make the output equal to the low-frequency clock. Codes 01 and 10 give the normal divide-by-2 and divide-by-4.
- R4: Writing 1 to bit 6 moves the output onto the ring oscillator. Writing 0 requests the crystal.
- R5: After reset the output runs from the crystal at divide-by-1.
- R6: The output never shows a high or low phase shorter than half the period of the fastest incoming clock, across any switch.
- R7: Until the crystal startup counter (XTAL_WAIT crystal cycles) has finished, a request for the crystal leaves the output on the ring oscillator. Once it has finished, the switch back takes place.
- R8: Read bit 5 is 1 only while the ring oscillator really drives the source path. It is still 0 in the cycle after a ring request is written, and it follows the request only after the handshake.
- R9: The byte reads 0x00 after reset. Bits 0, 1, 2 and 6 are writable. Writes to bits 3, 4, 5 and 7 have no effect, and bits 3, 4 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock of the register port and sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| hf_clk | input | 1 | High-frequency crystal or external clock |
| ring_clk | input | 1 | Internal ring oscillator clock |
| lf_clk | input | 1 | Low-frequency (32 kHz) clock |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Current control byte with live source status in bit 5 |
| sys_clk | output | 1 | Generated system clock |

## Verification
The bench builds the block with XTAL_WAIT = 400 instead of 65536. This makes the crystal startup window last about 5.6 µs, so a ring request followed by a crystal request can be issued inside it, and the held-off switch can be watched before and after the counter finishes. SYNC_STAGES and the 256 divider keep their defaults. The slowest output (ring divided by 256) is therefore measured directly, and the bench compares each output period and every phase width against values derived from the three input clock periods.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;

    typedef enum logic [1:0] {
        SRC_XTAL    = 2'd0,
        SRC_TO_RING = 2'd1,
        SRC_RING    = 2'd2,
        SRC_TO_XTAL = 2'd3
    } src_state_e;

    typedef enum logic {
        XW_COUNT = 1'b0,
        XW_DONE  = 1'b1
    } xwait_state_e;

    localparam int SRC_CH   = 2;
    localparam int RATIO_CH = 6;
    localparam int CH_XTAL  = 0;
    localparam int CH_RING  = 1;

    localparam int RT_DIV1  = 0;
    localparam int RT_DIV2  = 1;
    localparam int RT_DIV4  = 2;
    localparam int RT_DIV8  = 3;
    localparam int RT_PMDIV = 4;
    localparam int RT_LF    = 5;

    localparam logic [7:0] WR_MASK = 8'h47;

    function automatic logic [RATIO_CH-1:0] ratio_onehot(input logic pmm, input logic [1:0] cd);
        logic [RATIO_CH-1:0] oh;
        oh = '0;
        if (!pmm) begin
            oh[cd] = 1'b1;
        end else begin
            unique case (cd)
                2'b00:   oh[RT_PMDIV] = 1'b1;
                2'b01:   oh[RT_DIV2]  = 1'b1;
                2'b10:   oh[RT_DIV4]  = 1'b1;
                default: oh[RT_LF]    = 1'b1;
            endcase
        end
        return oh;
    endfunction

endpackage

// File: rtl/clkgen_sync.sv
`timescale 1ns/1ps
module clkgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_xtal_wait.sv
`timescale 1ns/1ps
module clkgen_xtal_wait
    import clkgen_pkg::*;
#(
    parameter int CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    xwait_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XW_COUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == XW_COUNT) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XW_COUNT: if (cnt_q == LAST) state_d = XW_DONE;
            XW_DONE:  state_d = XW_DONE;
        endcase
    end

    always_comb begin
        done_o = (state_q == XW_DONE);
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> done_o); // R7
endmodule

// File: rtl/clkgen_gf_mux.sv
`timescale 1ns/1ps
module clkgen_gf_mux #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic [N-1:0] clk_in,
    input  logic         rst_n,
    input  logic [N-1:0] sel_oh,
    output logic [N-1:0] en_o,
    output logic         clk_o
);
    logic [N-1:0] en_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        localparam logic [N-1:0] OTHERS = ~(N'(1) << i);
        logic arm;
        logic armed;
        logic en_ch;

        assign arm = sel_oh[i] & ~|(en_q & OTHERS);

        clkgen_sync #(.STAGES(STAGES)) u_sync (
            .clk   (clk_in[i]),
            .rst_n (rst_n),
            .d     (arm),
            .q     (armed)
        );

        always_ff @(negedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) en_ch <= 1'b0;
            else        en_ch <= armed;
        end

        assign en_q[i] = en_ch;

        AST_ONE_LIVE: assert property (@(negedge clk_in[i]) disable iff (!rst_n) $onehot0(en_q)); // R6
    end

    assign en_o  = en_q;
    assign clk_o = |(clk_in & en_q);
endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                bus_clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                xtal_done,
    input  logic [SRC_CH-1:0]   src_en,
    output logic [SRC_CH-1:0]   src_sel_oh,
    output logic [RATIO_CH-1:0] ratio_oh,
    output logic [7:0]          rd_data
);
    src_state_e state_q, state_d;
    logic       ring_req_q, pmm_q;
    logic [1:0] cd_q;
    logic       ring_ack_s, xtal_ack_s, xtal_ok_s;
    logic       on_ring;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_req_q <= 1'b0;
            pmm_q      <= 1'b0;
            cd_q       <= 2'b00;
        end else if (wr_en) begin
            ring_req_q <= wr_data[6];
            pmm_q      <= wr_data[2];
            cd_q       <= wr_data[1:0];
        end
    end

    clkgen_sync #(.STAGES(SYNC_STAGES)) u_s_ring (
        .clk(bus_clk), .rst_n(rst_n), .d(src_en[CH_RING]), .q(ring_ack_s));
    clkgen_sync #(.STAGES(SYNC_STAGES)) u_s_xtal (
        .clk(bus_clk), .rst_n(rst_n), .d(src_en[CH_XTAL]), .q(xtal_ack_s));
    clkgen_sync #(.STAGES(SYNC_STAGES)) u_s_done (
        .clk(bus_clk), .rst_n(rst_n), .d(xtal_done), .q(xtal_ok_s));

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_XTAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_XTAL:    if (ring_req_q)               state_d = SRC_TO_RING;
            SRC_TO_RING: if (ring_ack_s)               state_d = SRC_RING;
            SRC_RING:    if (!ring_req_q && xtal_ok_s) state_d = SRC_TO_XTAL;
            SRC_TO_XTAL: if (xtal_ack_s)               state_d = SRC_XTAL;
        endcase
    end

    always_comb begin
        src_sel_oh = '0;
        on_ring    = 1'b0;
        unique case (state_q)
            SRC_XTAL:    src_sel_oh[CH_XTAL] = 1'b1;
            SRC_TO_RING: src_sel_oh[CH_RING] = 1'b1;
            SRC_RING: begin
                src_sel_oh[CH_RING] = 1'b1;
                on_ring             = 1'b1;
            end
            SRC_TO_XTAL: begin
                src_sel_oh[CH_XTAL] = 1'b1;
                on_ring             = 1'b1;
            end
        endcase
        ratio_oh = ratio_onehot(pmm_q, cd_q);
        rd_data  = {1'b0, ring_req_q, on_ring, 2'b00, pmm_q, cd_q};
    end

    AST_STATUS_RISE: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(rd_data[5]) |-> $past(ring_ack_s)); // R8
    AST_STATUS_FALL: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $fell(rd_data[5]) |-> $past(xtal_ack_s)); // R8
    AST_XTAL_HOLDOFF: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (state_q == SRC_RING && !xtal_ok_s) |=> (state_q == SRC_RING)); // R7
    AST_WRITE_MASK: assert property (@(posedge bus_clk) disable iff (!rst_n)
        wr_en |=> ((rd_data & WR_MASK) == ($past(wr_data) & WR_MASK))); // R9
endmodule

// File: rtl/clkgen_top.sv
`timescale 1ns/1ps
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int XTAL_WAIT   = 65536,
    parameter int PM_LOG2     = 8
) (
    input  logic       bus_clk,
    input  logic       rst_n,
    input  logic       hf_clk,
    input  logic       ring_clk,
    input  logic       lf_clk,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       sys_clk
);
    logic                xtal_done;
    logic [SRC_CH-1:0]   src_sel_oh, src_en;
    logic [RATIO_CH-1:0] ratio_oh, ratio_en;
    logic [RATIO_CH-1:0] ratio_clks;
    logic                src_clk;
    logic [PM_LOG2-1:0]  div_cnt;

    clkgen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .bus_clk    (bus_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .xtal_done  (xtal_done),
        .src_en     (src_en),
        .src_sel_oh (src_sel_oh),
        .ratio_oh   (ratio_oh),
        .rd_data    (rd_data)
    );

    clkgen_xtal_wait #(.CYCLES(XTAL_WAIT)) u_xwait (
        .clk    (hf_clk),
        .rst_n  (rst_n),
        .done_o (xtal_done)
    );

    clkgen_gf_mux #(.N(SRC_CH), .STAGES(SYNC_STAGES)) u_src_mux (
        .clk_in (ring_clk ? 2'b10 | {1'b0, hf_clk} : {1'b0, hf_clk}),
        .rst_n  (rst_n),
        .sel_oh (src_sel_oh),
        .en_o   (src_en),
        .clk_o  (src_clk)
    );

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    always_comb begin
        ratio_clks           = '0;
        ratio_clks[RT_DIV1]  = src_clk;
        ratio_clks[RT_DIV2]  = div_cnt[0];
        ratio_clks[RT_DIV4]  = div_cnt[1];
        ratio_clks[RT_DIV8]  = div_cnt[2];
        ratio_clks[RT_PMDIV] = div_cnt[PM_LOG2-1];
        ratio_clks[RT_LF]    = lf_clk;
    end

    clkgen_gf_mux #(.N(RATIO_CH), .STAGES(SYNC_STAGES)) u_ratio_mux (
        .clk_in (ratio_clks),
        .rst_n  (rst_n),
        .sel_oh (ratio_oh),
        .en_o   (ratio_en),
        .clk_o  (sys_clk)
    );
endmodule

// File: tb/clkgen_top_tb_top.sv
`timescale 1ns/1ps
module clkgen_top_tb_top;
    localparam real BUS_HALF  = 10.0;
    localparam real HF_T      = 14.0;
    localparam real RING_T    = 22.0;
    localparam real LF_T      = 400.0;
    localparam real MIN_PHASE = 6.9;

    logic       bus_clk = 1'b0, hf_clk = 1'b0, ring_clk = 1'b0, lf_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sys_clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  n_runts = 0;
    bit  mon_on  = 1'b0;
    real last_edge = 0.0;

    always #(BUS_HALF)   bus_clk  = ~bus_clk;
    always #(HF_T/2.0)   hf_clk   = ~hf_clk;
    always #(RING_T/2.0) ring_clk = ~ring_clk;
    always #(LF_T/2.0)   lf_clk   = ~lf_clk;

    clkgen_top #(.SYNC_STAGES(2), .XTAL_WAIT(400), .PM_LOG2(8)) dut_i (
        .bus_clk  (bus_clk),
        .rst_n    (rst_n),
        .hf_clk   (hf_clk),
        .ring_clk (ring_clk),
        .lf_clk   (lf_clk),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sys_clk  (sys_clk)
    );

    always @(sys_clk) begin
        if (mon_on && ($realtime - last_edge) < MIN_PHASE) n_runts++;
        last_edge = $realtime;
    end

    function automatic real exp_period(input logic [7:0] v);
        real src;
        src = v[6] ? RING_T : HF_T;
        if (v[2] && v[1:0] == 2'b00) return src * 256.0;
        if (v[2] && v[1:0] == 2'b11) return LF_T;
        return src * real'(1 << v[1:0]);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] v, input logic on_ring);
        return {1'b0, v[6], on_ring, 2'b00, v[2:0]};
    endfunction

    task automatic chk_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: read 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic chk_period(input string req, input real exp);
        real t0, t1;
        @(posedge sys_clk);
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        t1 = $realtime;
        n_tests++;
        if ((t1 - t0) > exp + 0.5 || (t1 - t0) < exp - 0.5) begin
            n_fail++;
            $display("FAIL %s: period %0.2f ns expected %0.2f ns", req, t1 - t0, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] v);
        @(negedge bus_clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge bus_clk);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run();
        n_tests++;
        if (n_runts != 0) begin
            n_fail++;
            $display("FAIL R6: %0d short phases seen, expected 0", n_runts);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #3000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run still busy at %0t, expected done", $realtime);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        #95;
        chk_byte("R9 reset value", rd_data, 8'h00);
        rst_n = 1'b1;
        #300;
        mon_on = 1'b1;
        chk_period("R5 default crystal div1", HF_T);

        // R4 / R8: request ring, status lags
        write_byte(8'h40);
        chk_byte("R8 status lags request", rd_data, 8'h40);
        #1000;
        chk_byte("R4 R8 ring active", rd_data, 8'h60);
        chk_period("R4 ring period", RING_T);

        // R7: crystal requested before startup completes
        write_byte(8'h00);
        #1500;
        chk_byte("R7 held on ring", rd_data, 8'h20);
        chk_period("R7 ring period while held", RING_T);
        #5000;
        chk_byte("R7 R8 back on crystal", rd_data, 8'h00);
        chk_period("R7 crystal period after startup", HF_T);

        // R9: masked bits
        write_byte(8'hB8);
        #1000;
        chk_byte("R9 ignored bits", rd_data, 8'h00);
        chk_period("R9 ignored bits keep div1", HF_T);

        // R1 R2 R3: every ratio code on the crystal
        for (int c = 0; c < 8; c++) begin
            v = 8'(c);
            write_byte(v);
            #25000;
            chk_byte("R1 R2 R3 ratio readback", rd_data, exp_read(v, 1'b0));
            if (v[2] && v[1:0] == 2'b00)      chk_period("R2 div256", exp_period(v));
            else if (v[2] && v[1:0] == 2'b11) chk_period("R3 low-frequency", exp_period(v));
            else if (v[2])                    chk_period("R3 pm normal ratio", exp_period(v));
            else                              chk_period("R1 ratio", exp_period(v));
        end

        // Random source and ratio mixes
        for (int k = 0; k < 12; k++) begin
            v = 8'($urandom());
            write_byte(v);
            #30000;
            chk_byte("R4 R8 R9 random readback", rd_data, exp_read(v, v[6]));
            chk_period("R1 R2 R3 R4 random period", exp_period(v));
        end

        // Ring with div256 then low-frequency: slowest corner
        write_byte(8'h44);
        #30000;
        chk_period("R2 ring div256", RING_T * 256.0);
        write_byte(8'h47);
        #30000;
        chk_period("R3 low-frequency from ring", LF_T);

        finish_run();
    end
endmodule